// File: doc/BRIEF.md
# Eight-bit ALU with status flags

This block is the combinational arithmetic and logic stage of a small eight-bit processor datapath. Each cycle it takes two operands, a five-bit operation selector and the current status flags. In the same cycle it returns the operation result, a merged status vector and a flag write mask. A separate result-write strobe tells the register file whether the result should be stored. The block holds no state, so its outputs follow its inputs with no clock latency.

The status vector carries six flags at fixed positions: C at bit 0, Z at bit 1, N at bit 2, V at bit 3, S at bit 4 and H at bit 5. Every operation writes only some of these flags. `flag_mask` shows which ones. `flags_out` holds the newly computed value in each masked position and copies `flags_in` in every other position, so the surrounding status register can load `flags_out` directly.

The operation codes are: 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 CP, 5 CPC, 6 AND, 7 OR, 8 XOR, 9 COM, 10 NEG, 11 LSL, 12 LSR, 13 ROL, 14 ROR, 15 ASR, 16 SWAP. Codes 17 to 31 are unassigned. There is no state machine. The only sequencing is the fixed order in which the carry, half-carry, overflow, zero and sign flags are derived from one shared carry chain.

Top module: `alu8_core`

## Requirements
- R1: ADD (code 0) gives a+b, and ADC (code 1) gives a+b+C. Both write all six flags. C is the carry out of bit 7. H is the carry out of bit 3. V is the signed overflow. Z means the result is zero. N is result bit 7.
- R2: SUB (code 2) gives a-b, and SBC (code 3) gives a-b-C. Both write all six flags. C is the borrow out of bit 7, H is the borrow out of bit 3, and V is the signed overflow. For SUB, Z means the result is zero.
- R3: For SBC (code 3) and CPC (code 5), Z out is (result==0) AND Z in. A cleared incoming Z therefore always stays cleared.
- R4: CP (code 4) and CPC (code 5) produce the flags of SUB and SBC respectively, and hold `result_we` low.
- R5: AND, OR and XOR (codes 6, 7, 8) write only Z, N, V and S, and V is forced to 0. C and H keep their incoming values.
- R6: COM (code 9) gives 0xFF-a. It sets C to 1 and clears V, writes Z, N and S, and keeps H.
- R7: NEG (code 10) gives 0x00-a and writes all six flags. C is set when a is nonzero, H is set when a[3:0] is nonzero, and V is set when a is 0x80.
- R8: LSL (code 11) shifts in 0 at bit 0, and C takes the old bit 7. LSR (code 12) shifts in 0 at bit 7, and C takes the old bit 0.
- R9: ROL (code 13) moves the incoming C into bit 0, and C takes the old bit 7. ROR (code 14) moves the incoming C into bit 7, and C takes the old bit 0.
- R10: ASR (code 15) shifts right and keeps bit 7 unchanged. C takes the old bit 0.
- R11: The shift and rotate codes 11 to 15 write C, Z, N, V and S, with V equal to N XOR C of the new values. H keeps its incoming value.
- R12: SWAP (code 16) exchanges the two nibbles. `flag_mask` is 0 and `flags_out` equals `flags_in`.
- R13: Whenever the mask includes S (bit 4), S out equals N out XOR V out. Flags outside the mask always equal their `flags_in` value.
- R14: The unassigned codes 17 to 31 return `op_a` as the result, a mask of 0, `flags_out` equal to `flags_in`, and `result_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 8 | First operand (the destination value) |
| op_b | input | 8 | Second operand |
| op_sel | input | 5 | Operation code |
| flags_in | input | 6 | Current flags {H,S,V,N,Z,C} |
| result | output | 8 | Operation result |
| flags_out | output | 6 | Merged flags {H,S,V,N,Z,C} |
| flag_mask | output | 6 | Flags written by this operation |
| result_we | output | 1 | Result should be written back |

## Verification
The bench builds the block with its default width of 8. This makes the half-carry position bit 3 and the signed range -128 to 127. At that width, directed vectors reach the exact corners: 0x7F+1, 0x80+0x80, 0x0F+1, 0-1 with carry, NEG of 0x00 and of 0x80, and equal operands under a chained compare with Z both set and cleared. Several thousand random operand, code and incoming-flag combinations then cover every code, including the unassigned ones. Each one is compared against an integer-arithmetic model of the flag rules.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int FLAG_W = 6;
    localparam int FL_C   = 0;
    localparam int FL_Z   = 1;
    localparam int FL_N   = 2;
    localparam int FL_V   = 3;
    localparam int FL_S   = 4;
    localparam int FL_H   = 5;

    localparam logic [FLAG_W-1:0] MASK_ALL   = 6'b111111;
    localparam logic [FLAG_W-1:0] MASK_LOGIC = 6'b011110;
    localparam logic [FLAG_W-1:0] MASK_SHIFT = 6'b011111;
    localparam logic [FLAG_W-1:0] MASK_NONE  = 6'b000000;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CP   = 5'd4,
        OP_CPC  = 5'd5,
        OP_AND  = 5'd6,
        OP_OR   = 5'd7,
        OP_XOR  = 5'd8,
        OP_COM  = 5'd9,
        OP_NEG  = 5'd10,
        OP_LSL  = 5'd11,
        OP_LSR  = 5'd12,
        OP_ROL  = 5'd13,
        OP_ROR  = 5'd14,
        OP_ASR  = 5'd15,
        OP_SWAP = 5'd16
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_kind_e;

    typedef enum logic [2:0] {
        SH_LSL  = 3'd0,
        SH_LSR  = 3'd1,
        SH_ROL  = 3'd2,
        SH_ROR  = 3'd3,
        SH_ASR  = 3'd4,
        SH_SWAP = 3'd5
    } shift_kind_e;

    typedef enum logic [2:0] {
        G_PASS  = 3'd0,
        G_ARITH = 3'd1,
        G_LOGIC = 3'd2,
        G_COM   = 3'd3,
        G_SHIFT = 3'd4
    } res_group_e;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              sub,
    output logic [DATA_W-1:0] res,
    output logic              c_out,
    output logic              h_out,
    output logic              v_out
);
    localparam int HALF = DATA_W / 2;
    localparam int MSB  = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic              c_eff;
    logic [DATA_W:0]   full_sum;
    logic [HALF:0]     low_sum;

    always_comb begin
        b_eff    = sub ? ~b : b;
        c_eff    = sub ? ~cin : cin;
        full_sum = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_eff};
        low_sum  = {1'b0, a[HALF-1:0]} + {1'b0, b_eff[HALF-1:0]} + {{HALF{1'b0}}, c_eff};
        res      = full_sum[DATA_W-1:0];
        c_out    = sub ? ~full_sum[DATA_W] : full_sum[DATA_W];
        h_out    = sub ? ~low_sum[HALF] : low_sum[HALF];
        v_out    = (a[MSB] == b_eff[MSB]) && (full_sum[MSB] != a[MSB]);
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic_kind_e       kind,
    output logic [DATA_W-1:0] res
);
    always_comb begin
        unique case (kind)
            LG_AND:  res = a & b;
            LG_OR:   res = a | b;
            LG_XOR:  res = a ^ b;
            default: res = a;
        endcase
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic              cin,
    input  shift_kind_e       kind,
    output logic [DATA_W-1:0] res,
    output logic              c_out
);
    localparam int HALF = DATA_W / 2;
    localparam int MSB  = DATA_W - 1;

    always_comb begin
        res   = a;
        c_out = cin;
        unique case (kind)
            SH_LSL: begin
                res   = {a[MSB-1:0], 1'b0};
                c_out = a[MSB];
            end
            SH_LSR: begin
                res   = {1'b0, a[MSB:1]};
                c_out = a[0];
            end
            SH_ROL: begin
                res   = {a[MSB-1:0], cin};
                c_out = a[MSB];
            end
            SH_ROR: begin
                res   = {cin, a[MSB:1]};
                c_out = a[0];
            end
            SH_ASR: begin
                res   = {a[MSB], a[MSB:1]};
                c_out = a[0];
            end
            SH_SWAP: begin
                res   = {a[HALF-1:0], a[MSB:HALF]};
                c_out = cin;
            end
            default: begin
                res   = a;
                c_out = cin;
            end
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [4:0]        op_sel,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [DATA_W-1:0] result,
    output logic [FLAG_W-1:0] flags_out,
    output logic [FLAG_W-1:0] flag_mask,
    output logic              result_we
);
    localparam int MSB = DATA_W - 1;

    alu_op_e           op_e;
    res_group_e        group;
    logic [DATA_W-1:0] ar_a;
    logic [DATA_W-1:0] ar_b;
    logic              ar_cin;
    logic              ar_sub;
    logic [DATA_W-1:0] ar_res;
    logic              ar_c;
    logic              ar_h;
    logic              ar_v;
    logic_kind_e       lg_kind;
    logic [DATA_W-1:0] lg_res;
    shift_kind_e       sh_kind;
    logic [DATA_W-1:0] sh_res;
    logic              sh_c;
    logic              z_chain;
    logic [FLAG_W-1:0] mask_d;
    logic              we_d;
    logic [DATA_W-1:0] res_d;
    logic              c_n;
    logic              z_n;
    logic              n_n;
    logic              v_n;
    logic              h_n;
    logic [FLAG_W-1:0] cand;

    assign op_e = alu_op_e'(op_sel);

    // Operation decode: operand routing, result group, flag mask, write strobe
    always_comb begin
        ar_a    = op_a;
        ar_b    = op_b;
        ar_cin  = 1'b0;
        ar_sub  = 1'b0;
        group   = G_PASS;
        mask_d  = MASK_NONE;
        we_d    = 1'b0;
        z_chain = 1'b0;
        lg_kind = LG_AND;
        sh_kind = SH_LSL;
        unique case (op_e)
            OP_ADD: begin
                group = G_ARITH; mask_d = MASK_ALL; we_d = 1'b1;
            end
            OP_ADC: begin
                group = G_ARITH; mask_d = MASK_ALL; we_d = 1'b1;
                ar_cin = flags_in[FL_C];
            end
            OP_SUB: begin
                group = G_ARITH; mask_d = MASK_ALL; we_d = 1'b1;
                ar_sub = 1'b1;
            end
            OP_SBC: begin
                group = G_ARITH; mask_d = MASK_ALL; we_d = 1'b1;
                ar_sub = 1'b1; ar_cin = flags_in[FL_C]; z_chain = 1'b1;
            end
            OP_CP: begin
                group = G_ARITH; mask_d = MASK_ALL;
                ar_sub = 1'b1;
            end
            OP_CPC: begin
                group = G_ARITH; mask_d = MASK_ALL;
                ar_sub = 1'b1; ar_cin = flags_in[FL_C]; z_chain = 1'b1;
            end
            OP_AND: begin
                group = G_LOGIC; mask_d = MASK_LOGIC; we_d = 1'b1; lg_kind = LG_AND;
            end
            OP_OR: begin
                group = G_LOGIC; mask_d = MASK_LOGIC; we_d = 1'b1; lg_kind = LG_OR;
            end
            OP_XOR: begin
                group = G_LOGIC; mask_d = MASK_LOGIC; we_d = 1'b1; lg_kind = LG_XOR;
            end
            OP_COM: begin
                group = G_COM; mask_d = MASK_SHIFT; we_d = 1'b1;
            end
            OP_NEG: begin
                group = G_ARITH; mask_d = MASK_ALL; we_d = 1'b1;
                ar_a = '0; ar_b = op_a; ar_sub = 1'b1;
            end
            OP_LSL: begin
                group = G_SHIFT; mask_d = MASK_SHIFT; we_d = 1'b1; sh_kind = SH_LSL;
            end
            OP_LSR: begin
                group = G_SHIFT; mask_d = MASK_SHIFT; we_d = 1'b1; sh_kind = SH_LSR;
            end
            OP_ROL: begin
                group = G_SHIFT; mask_d = MASK_SHIFT; we_d = 1'b1; sh_kind = SH_ROL;
            end
            OP_ROR: begin
                group = G_SHIFT; mask_d = MASK_SHIFT; we_d = 1'b1; sh_kind = SH_ROR;
            end
            OP_ASR: begin
                group = G_SHIFT; mask_d = MASK_SHIFT; we_d = 1'b1; sh_kind = SH_ASR;
            end
            OP_SWAP: begin
                group = G_SHIFT; mask_d = MASK_NONE; we_d = 1'b1; sh_kind = SH_SWAP;
            end
            default: begin
                group = G_PASS;
            end
        endcase
    end

    alu8_arith #(.DATA_W(DATA_W)) u_arith (
        .a     (ar_a),
        .b     (ar_b),
        .cin   (ar_cin),
        .sub   (ar_sub),
        .res   (ar_res),
        .c_out (ar_c),
        .h_out (ar_h),
        .v_out (ar_v)
    );

    alu8_logic #(.DATA_W(DATA_W)) u_logic (
        .a    (op_a),
        .b    (op_b),
        .kind (lg_kind),
        .res  (lg_res)
    );

    alu8_shift #(.DATA_W(DATA_W)) u_shift (
        .a     (op_a),
        .cin   (flags_in[FL_C]),
        .kind  (sh_kind),
        .res   (sh_res),
        .c_out (sh_c)
    );

    // Result selection and flag derivation
    always_comb begin
        unique case (group)
            G_ARITH: res_d = ar_res;
            G_LOGIC: res_d = lg_res;
            G_COM:   res_d = ~op_a;
            G_SHIFT: res_d = sh_res;
            default: res_d = op_a;
        endcase

        unique case (group)
            G_ARITH: begin c_n = ar_c;           h_n = ar_h;           end
            G_COM:   begin c_n = 1'b1;           h_n = flags_in[FL_H]; end
            G_SHIFT: begin c_n = sh_c;           h_n = flags_in[FL_H]; end
            default: begin c_n = flags_in[FL_C]; h_n = flags_in[FL_H]; end
        endcase

        n_n = res_d[MSB];
        z_n = (res_d == '0) && (!z_chain || flags_in[FL_Z]);

        unique case (group)
            G_ARITH: v_n = ar_v;
            G_SHIFT: v_n = n_n ^ c_n;
            default: v_n = 1'b0;
        endcase

        cand        = '0;
        cand[FL_C]  = c_n;
        cand[FL_Z]  = z_n;
        cand[FL_N]  = n_n;
        cand[FL_V]  = v_n;
        cand[FL_S]  = n_n ^ v_n;
        cand[FL_H]  = h_n;
    end

    assign result    = res_d;
    assign flag_mask = mask_d;
    assign result_we = we_d;
    assign flags_out = (flags_in & ~mask_d) | (cand & mask_d);

endmodule

// File: rtl/alu8_checker.sv
module alu8_checker
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic [DATA_W-1:0] op_a,
    input logic [4:0]        op_sel,
    input logic [FLAG_W-1:0] flags_in,
    input logic [DATA_W-1:0] result,
    input logic [FLAG_W-1:0] flags_out,
    input logic [FLAG_W-1:0] flag_mask,
    input logic              result_we
);
    always_comb begin
        if (!$isunknown({op_a, op_sel, flags_in, result, flags_out, flag_mask, result_we})) begin
            // R3: chained subtract/compare never newly sets Z
            if ((op_sel == OP_SBC || op_sel == OP_CPC) && !flags_in[FL_Z]) begin
                p_chain_zero_r3: assert (!flags_out[FL_Z])
                    else $error("R3 chained Z set from clear");
            end
            // R4: compares never request a write-back
            if (op_sel == OP_CP || op_sel == OP_CPC) begin
                p_cmp_no_write_r4: assert (!result_we)
                    else $error("R4 compare wrote result");
            end
            // R5: logic ops clear V and keep C and H
            if (op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_XOR) begin
                p_logic_flags_r5: assert (!flags_out[FL_V] && flags_out[FL_C] == flags_in[FL_C]
                                          && flags_out[FL_H] == flags_in[FL_H])
                    else $error("R5 logic flag rule broken");
            end
            // R6: complement sets carry
            if (op_sel == OP_COM) begin
                p_com_carry_r6: assert (flags_out[FL_C] && !flags_out[FL_V])
                    else $error("R6 complement flags");
            end
            // R11: shifts set V to N xor C
            if (op_sel >= OP_LSL && op_sel <= OP_ASR) begin
                p_shift_v_r11: assert (flags_out[FL_V] == (flags_out[FL_N] ^ flags_out[FL_C]))
                    else $error("R11 shift V rule");
            end
            // R12: swap touches no flag
            if (op_sel == OP_SWAP) begin
                p_swap_flags_r12: assert (flags_out == flags_in)
                    else $error("R12 swap changed flags");
            end
            // R13: sign is N xor V whenever written
            if (flag_mask[FL_S]) begin
                p_sign_rule_r13: assert (flags_out[FL_S] == (flags_out[FL_N] ^ flags_out[FL_V]))
                    else $error("R13 sign rule");
            end
            // R14: unassigned codes pass through
            if (op_sel > OP_SWAP) begin
                p_unassigned_r14: assert (result == op_a && !result_we && flags_out == flags_in)
                    else $error("R14 unassigned code");
            end
        end
    end
endmodule

bind alu8_core alu8_checker #(.DATA_W(DATA_W)) u_alu8_checker (
    .op_a      (op_a),
    .op_sel    (op_sel),
    .flags_in  (flags_in),
    .result    (result),
    .flags_out (flags_out),
    .flag_mask (flag_mask),
    .result_we (result_we)
);

// File: tb/test_alu8_core.sv
module test_alu8_core;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;
    localparam int N_RANDOM   = 4000;

    logic       clk;
    logic       rst_n;
    logic [7:0] op_a;
    logic [7:0] op_b;
    logic [4:0] op_sel;
    logic [5:0] flags_in;
    logic [7:0] result;
    logic [5:0] flags_out;
    logic [5:0] flag_mask;
    logic       result_we;

    int checks;
    int failures;
    bit done;

    alu8_core #(.DATA_W(8)) i_alu8_core (
        .op_a      (op_a),
        .op_b      (op_b),
        .op_sel    (op_sel),
        .flags_in  (flags_in),
        .result    (result),
        .flags_out (flags_out),
        .flag_mask (flag_mask),
        .result_we (result_we)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int sx(input int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    function automatic string tag_of(input int op);
        case (op)
            0, 1:    return "R1";
            2, 3:    return "R2";
            4, 5:    return "R4";
            6, 7, 8: return "R5";
            9:       return "R6";
            10:      return "R7";
            11, 12:  return "R8";
            13, 14:  return "R9";
            15:      return "R10";
            16:      return "R12";
            default: return "R14";
        endcase
    endfunction

    // Behavioural reference built on integer arithmetic
    task automatic model(input int op, input int a, input int b, input int fin,
                         output int r, output int fo, output int m, output int we);
        int c, z, cin, d, ss, cand;
        int fc, fz, fn, fv, fs, fh;
        bit chain;
        c = fin & 1; z = (fin >> 1) & 1;
        fc = c; fh = (fin >> 5) & 1; fv = 0;
        chain = 0; r = a; m = 0; we = 0;
        case (op)
            0, 1: begin
                cin = (op == 1) ? c : 0;
                d = a + b + cin; r = d & 255; fc = (d > 255);
                fh = (((a & 15) + (b & 15) + cin) > 15);
                ss = sx(a) + sx(b) + cin; fv = (ss > 127 || ss < -128);
                m = 63; we = 1;
            end
            2, 3, 4, 5: begin
                cin = (op == 3 || op == 5) ? c : 0;
                d = a - b - cin; r = d & 255; fc = (d < 0);
                fh = (((a & 15) - (b & 15) - cin) < 0);
                ss = sx(a) - sx(b) - cin; fv = (ss > 127 || ss < -128);
                chain = (op == 3 || op == 5);
                m = 63; we = (op < 4);
            end
            6, 7, 8: begin
                r = (op == 6) ? (a & b) : (op == 7) ? (a | b) : (a ^ b);
                fv = 0; m = 30; we = 1;
            end
            9: begin
                r = 255 - a; fc = 1; fv = 0; m = 31; we = 1;
            end
            10: begin
                r = (256 - a) & 255; fc = (a != 0); fh = ((a & 15) != 0);
                fv = (a == 128); m = 63; we = 1;
            end
            11, 12, 13, 14, 15: begin
                case (op)
                    11: begin r = (a * 2) & 255;           fc = a / 128; end
                    12: begin r = a / 2;                   fc = a % 2;   end
                    13: begin r = ((a * 2) & 255) + c;     fc = a / 128; end
                    14: begin r = a / 2 + c * 128;         fc = a % 2;   end
                    default: begin r = a / 2 + (a & 128);  fc = a % 2;   end
                endcase
                fv = ((r / 128) != fc) ? 1 : 0;
                m = 31; we = 1;
            end
            16: begin
                r = (a % 16) * 16 + a / 16; m = 0; we = 1;
            end
            default: begin
                r = a; m = 0; we = 0;
            end
        endcase
        fz = (r == 0) ? 1 : 0;
        if (chain) fz = fz & z;
        fn = r / 128;
        fs = fn ^ fv;
        cand = fc | (fz << 1) | (fn << 2) | (fv << 3) | (fs << 4) | (fh << 5);
        fo = (fin & ~m & 63) | (cand & m);
    endtask

    task automatic check(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s got=%0h exp=%0h (op=%0d a=%0h b=%0h fin=%0h)",
                     tag, what, got, exp, op_sel, op_a, op_b, flags_in);
        end
    endtask

    task automatic apply(input int op, input int a, input int b, input int fin);
        int er, efo, em, ewe;
        @(posedge clk);
        #1;
        op_sel = 5'(op); op_a = 8'(a); op_b = 8'(b); flags_in = 6'(fin);
        model(op, a, b, fin, er, efo, em, ewe);
        @(negedge clk);
        if (ewe != 0 || op > 16) check(tag_of(op), "result", int'(result), er);
        check(tag_of(op), "flags", int'(flags_out), efo);
        check("R13", "mask", int'(flag_mask), em);
        check(tag_of(op), "we", int'(result_we), ewe);
        if ((op == 3 || op == 5) && ((fin >> 1) & 1) == 0)
            check("R3", "chained Z", int'(flags_out[1]), 0);
        if (op >= 11 && op <= 15)
            check("R11", "shift V", int'(flags_out[3]), int'(flags_out[2] ^ flags_out[0]));
        if (flag_mask[4])
            check("R13", "sign", int'(flags_out[4]), int'(flags_out[2] ^ flags_out[3]));
    endtask

    initial begin
        int w;
        for (w = 0; w < WATCHDOG; w++) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired (all requirements)");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        checks = 0; failures = 0; done = 0;
        rst_n = 1'b0;
        op_sel = 5'd0; op_a = 8'h00; op_b = 8'h00; flags_in = 6'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state: zero inputs under ADD give zero result with Z set (R1)
        check("R1", "reset result", int'(result), 0);
        check("R1", "reset flags", int'(flags_out), 6'b000010);
        rst_n = 1'b1;

        // R1 corners
        apply(0, 8'h7F, 8'h01, 0);
        apply(0, 8'h80, 8'h80, 0);
        apply(0, 8'h0F, 8'h01, 0);
        apply(1, 8'hFF, 8'h00, 1);
        apply(1, 8'h3C, 8'h44, 6'h3F);
        // R2 corners
        apply(2, 8'h00, 8'h01, 0);
        apply(2, 8'h80, 8'h01, 0);
        apply(3, 8'h10, 8'h0F, 1);
        // R3: equal operands under chaining with Z clear and Z set
        apply(3, 8'h55, 8'h55, 6'h00);
        apply(3, 8'h55, 8'h55, 6'h02);
        apply(5, 8'h20, 8'h1F, 6'h01);
        apply(5, 8'h20, 8'h1F, 6'h03);
        // R4
        apply(4, 8'h42, 8'h42, 0);
        // R5
        apply(6, 8'hF0, 8'h0F, 6'h21);
        apply(7, 8'h80, 8'h01, 6'h08);
        apply(8, 8'hAA, 8'hAA, 6'h3F);
        // R6, R7
        apply(9, 8'hFF, 8'h00, 6'h20);
        apply(10, 8'h00, 8'h00, 6'h3F);
        apply(10, 8'h80, 8'h00, 0);
        apply(10, 8'h01, 8'h00, 0);
        // R8..R11
        apply(11, 8'h80, 8'h00, 0);
        apply(12, 8'h01, 8'h00, 6'h20);
        apply(13, 8'h7F, 8'h00, 1);
        apply(14, 8'h01, 8'h00, 1);
        apply(15, 8'h81, 8'h00, 0);
        // R12, R14
        apply(16, 8'hA5, 8'h00, 6'h2B);
        apply(20, 8'h5A, 8'h11, 6'h15);
        apply(31, 8'hC3, 8'h77, 6'h2A);

        for (int i = 0; i < N_RANDOM; i++) begin
            apply(int'($urandom_range(0, 20)), int'($urandom_range(0, 255)),
                  int'($urandom_range(0, 255)), int'($urandom_range(0, 63)));
        end
        for (int op = 0; op < 32; op++) begin
            apply(op, 8'h00, 8'h00, 6'h00);
            apply(op, 8'hFF, 8'hFF, 6'h3F);
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule